// File: doc/BRIEF.md
# Age-Ordered Deflection Port Allocator

This block is the port-assignment stage of a four-input, four-output router that has no flit buffers. Each cycle up to four flits arrive, one per input. Each flit carries a valid bit, a flag marking it as newly injected traffic, an age timestamp and a mask of the output directions that bring it closer to its destination. The mask comes from route computation upstream. Because the router cannot hold a flit, every valid flit must leave on some output in the cycle it arrives. A flit that cannot get a productive port is sent out on a spare port, which is called a deflection.

The stage places the flits in a strict priority order using a three-stage comparator network. Flits already in the network rank ahead of injected ones. Within each of those classes, a smaller timestamp means an older flit and a higher rank. Equal timestamps go to the lower input index. Ports are then handed out one flit at a time in that order, and each flit may only take ports that higher-ranked flits have left free. The per-flit one-hot grant and the deflection flag are registered. The crossbar uses them on the following cycle.

Top module: `dfl_port_alloc`

## Requirements
- R1: A synchronous active-high reset clears every grant field and every deflection flag to zero on the next clock edge.
- R2: Each flit's result is registered. The inputs sampled at one rising edge appear on `gnt_o` and `defl_o` directly after that edge. Field i of `gnt_o` is bits 4i+3..4i and belongs to input i. Bit p of a field is output port p. A valid flit receives exactly one set bit.
- R3: An invalid flit receives an all-zero grant field and a zero deflection flag. It takes no port away from any other flit.
- R4: No output port is granted to more than one flit in the same cycle.
- R5: Priority order is as follows. Any non-injected valid flit outranks any injected valid flit. Within a class, the smaller unsigned timestamp ranks higher. For equal timestamps, the lower input index ranks higher.
- R6: Flits are served in priority order. A flit whose desired mask overlaps the ports still free takes the lowest-numbered port in that overlap, and its deflection flag is 0.
- R7: A valid flit whose desired mask has no overlap with the free ports takes the lowest-numbered free port, and its deflection flag is 1. An empty desired mask always deflects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 4 | Valid bit per input |
| in_inj | input | 4 | Per-input flag marking newly injected traffic |
| in_ts | input | 4*AGE_W | Timestamp per input; field i at bits AGE_W*i+AGE_W-1..AGE_W*i |
| in_want | input | 16 | Productive-direction mask per input; field i at bits 4i+3..4i |
| gnt_o | output | 16 | Registered one-hot port grant per input, same field layout as in_want |
| defl_o | output | 4 | Registered deflection flag per input |

## Verification
The bench sets up the following corner cases:
- Four flits that all want the same port. A design that ranked them wrongly would give the port to a younger flit.
- Equal timestamps. A design that broke the tie by input index the wrong way would show it here.
- An old injected flit competing with a young in-network flit. This exposes a design that lets injected traffic win on age alone.
- Invalid flits with non-empty masks. A design that let them hold a port would push a valid flit onto the wrong spare port.
- Empty desired masks, and a reset in the middle of traffic. These catch a missing deflection flag and a stale grant.

Long random runs with narrow timestamp ranges exercise ties heavily. Each one is compared against a bench model of the ordering and the port-handout rules.

// File: rtl/dfl_alloc_pkg.sv
package dfl_alloc_pkg;
   localparam int NPORT = 4;
   localparam int IDX_W = 2;

   // one-hot of the lowest set bit (zero when none)
   function automatic logic [NPORT-1:0] pick_low(input logic [NPORT-1:0] m);
      return m & (~m + NPORT'(1));
   endfunction
endpackage

// File: rtl/dfl_cmp_swap.sv
module dfl_cmp_swap #(
   parameter int RW = 16,
   parameter int KW = 8
) (
   input  logic [RW-1:0] a_i,
   input  logic [RW-1:0] b_i,
   output logic [RW-1:0] lo_o,
   output logic [RW-1:0] hi_o
);
   generate
      if (KW > RW || KW < 1) begin : g_bad
         $error("dfl_cmp_swap: key width must lie within record width");
      end
   endgenerate

   logic b_first;
   assign b_first = b_i[RW-1 -: KW] < a_i[RW-1 -: KW];
   assign lo_o    = b_first ? b_i : a_i;
   assign hi_o    = b_first ? a_i : b_i;
endmodule

// File: rtl/dfl_age_sorter.sv
module dfl_age_sorter
   import dfl_alloc_pkg::*;
#(
   parameter int RW = 16,
   parameter int KW = 8
) (
   input  logic [NPORT-1:0][RW-1:0] rec_i,
   output logic [NPORT-1:0][RW-1:0] rec_o
);
   logic [NPORT-1:0][RW-1:0] st1, st2;

   // stage 1: neighbouring pairs
   dfl_cmp_swap #(.RW(RW), .KW(KW)) u_s1a (.a_i(rec_i[0]), .b_i(rec_i[1]), .lo_o(st1[0]), .hi_o(st1[1]));
   dfl_cmp_swap #(.RW(RW), .KW(KW)) u_s1b (.a_i(rec_i[2]), .b_i(rec_i[3]), .lo_o(st1[2]), .hi_o(st1[3]));
   // stage 2: best and worst of each pair meet
   dfl_cmp_swap #(.RW(RW), .KW(KW)) u_s2a (.a_i(st1[0]), .b_i(st1[2]), .lo_o(st2[0]), .hi_o(st2[2]));
   dfl_cmp_swap #(.RW(RW), .KW(KW)) u_s2b (.a_i(st1[1]), .b_i(st1[3]), .lo_o(st2[1]), .hi_o(st2[3]));
   // stage 3: middle pair
   dfl_cmp_swap #(.RW(RW), .KW(KW)) u_s3  (.a_i(st2[1]), .b_i(st2[2]), .lo_o(rec_o[1]), .hi_o(rec_o[2]));
   assign rec_o[0] = st2[0];
   assign rec_o[3] = st2[3];
endmodule

// File: rtl/dfl_port_chain.sv
module dfl_port_chain
   import dfl_alloc_pkg::*;
#(
   parameter int RW = 16
) (
   input  logic [NPORT-1:0][RW-1:0]    rec_i,
   output logic [NPORT-1:0][NPORT-1:0] rank_gnt_o,
   output logic [NPORT-1:0]            rank_defl_o
);
   logic [NPORT:0][NPORT-1:0] free_c;
   assign free_c[0] = '1;

   for (genvar r = 0; r < NPORT; r++) begin : g_rank
      logic             vld;
      logic [NPORT-1:0] want, hit;
      assign vld  = ~rec_i[r][RW-1];
      assign want = rec_i[r][NPORT-1:0];
      assign hit  = want & free_c[r];

      always_comb begin
         rank_gnt_o[r]  = '0;
         rank_defl_o[r] = 1'b0;
         if (vld) begin
            if (hit != '0) begin
               rank_gnt_o[r] = pick_low(hit);
            end else begin
               rank_gnt_o[r]  = pick_low(free_c[r]);
               rank_defl_o[r] = 1'b1;
            end
         end
      end

      assign free_c[r+1] = free_c[r] & ~rank_gnt_o[r];
   end
endmodule

// File: rtl/dfl_port_alloc.sv
module dfl_port_alloc
   import dfl_alloc_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int AGE_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_IN-1:0]        in_vld,
   input  logic [N_IN-1:0]        in_inj,
   input  logic [N_IN*AGE_W-1:0]  in_ts,
   input  logic [N_IN*N_IN-1:0]   in_want,
   output logic [N_IN*N_IN-1:0]   gnt_o,
   output logic [N_IN-1:0]        defl_o
);
   localparam int KW = 2 + AGE_W + IDX_W;
   localparam int RW = KW + NPORT;

   generate
      if (N_IN != NPORT) begin : g_bad_n
         $error("dfl_port_alloc: the sort network is built for exactly four inputs");
      end
      if (AGE_W < 1 || AGE_W > 32) begin : g_bad_age
         $error("dfl_port_alloc: AGE_W out of range");
      end
   endgenerate

   logic [NPORT-1:0][AGE_W-1:0] ts_a;
   logic [NPORT-1:0][NPORT-1:0] want_a;
   assign ts_a   = in_ts;
   assign want_a = in_want;

   // record: {not-valid, injected, timestamp, index, want}; smaller key ranks higher
   logic [NPORT-1:0][RW-1:0] rec_in, rec_srt;
   for (genvar i = 0; i < NPORT; i++) begin : g_rec
      assign rec_in[i] = {~in_vld[i], in_inj[i], ts_a[i], IDX_W'(i), want_a[i]};
   end

   dfl_age_sorter #(.RW(RW), .KW(KW)) u_sort (.rec_i(rec_in), .rec_o(rec_srt));

   logic [NPORT-1:0][NPORT-1:0] rank_gnt;
   logic [NPORT-1:0]            rank_defl;
   dfl_port_chain #(.RW(RW)) u_chain (.rec_i(rec_srt), .rank_gnt_o(rank_gnt), .rank_defl_o(rank_defl));

   logic [NPORT-1:0][NPORT-1:0] gnt_d, gnt_q;
   logic [NPORT-1:0]            defl_d, defl_q;

   always_comb begin
      gnt_d  = '0;
      defl_d = '0;
      for (int r = 0; r < NPORT; r++) begin
         gnt_d[rec_srt[r][NPORT +: IDX_W]]  = rank_gnt[r];
         defl_d[rec_srt[r][NPORT +: IDX_W]] = rank_defl[r];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt_q  <= '0;
         defl_q <= '0;
      end else begin
         gnt_q  <= gnt_d;
         defl_q <= defl_d;
      end
   end

   assign gnt_o  = gnt_q;
   assign defl_o = defl_q;

   // per-port column of the registered grants
   logic [NPORT-1:0][NPORT-1:0] col_q;
   always_comb begin
      for (int p = 0; p < NPORT; p++)
         for (int i = 0; i < NPORT; i++)
            col_q[p][i] = gnt_q[i][p];
   end

   for (genvar i = 0; i < NPORT; i++) begin : g_chk
      a_r2_one_port: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(in_vld[i])) |-> ($countones(gnt_q[i]) == 1));
      a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(in_vld[i])) |-> (gnt_q[i] == '0 && !defl_q[i]));
      a_r6_productive: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(in_vld[i]) && !defl_q[i]) |-> ((gnt_q[i] & $past(want_a[i])) != '0));
      a_r7_deflect_away: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && defl_q[i]) |-> ((gnt_q[i] & $past(want_a[i])) == '0));
      a_r4_port_once: assert property (@(posedge clk) disable iff (rst)
         $onehot0(col_q[i]));
   end
endmodule

// File: tb/dfl_port_alloc_tb_top.sv
`timescale 1ns/1ps
module dfl_port_alloc_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    in_vld = '0, in_inj = '0;
   logic [4*AW-1:0] in_ts = '0;
   logic [15:0]   in_want = '0;
   logic [15:0]   gnt_o;
   logic [3:0]    defl_o;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dfl_port_alloc #(.N_IN(4), .AGE_W(AW)) dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_inj(in_inj),
      .in_ts(in_ts), .in_want(in_want), .gnt_o(gnt_o), .defl_o(defl_o));

   logic [3:0]    v, inj, exp_d;
   logic [AW-1:0] ts [4];
   logic [3:0]    w [4];
   logic [15:0]   exp_g;

   function automatic bit ranks_above(int a, int b);
      if (v[a] != v[b]) return v[a];
      if (inj[a] != inj[b]) return !inj[a];
      if (ts[a] != ts[b]) return ts[a] < ts[b];
      return a < b;
   endfunction

   function automatic logic [3:0] first_of(logic [3:0] m);
      for (int p = 0; p < 4; p++) if (m[p]) return 4'(1 << p);
      return 4'd0;
   endfunction

   task automatic model();
      int ord [4];
      bit used [4];
      logic [3:0] free, h, g;
      for (int k = 0; k < 4; k++) used[k] = 0;
      for (int r = 0; r < 4; r++) begin
         int best = -1;
         for (int k = 0; k < 4; k++)
            if (!used[k] && (best < 0 || ranks_above(k, best))) best = k;
         ord[r] = best;
         used[best] = 1;
      end
      free = 4'hF; exp_g = '0; exp_d = '0;
      for (int r = 0; r < 4; r++) begin
         int k = ord[r];
         if (v[k]) begin
            h = w[k] & free;
            if (h != 0) g = first_of(h);
            else begin g = first_of(free); exp_d[k] = 1'b1; end
            exp_g[4*k +: 4] = g;
            free = free & ~g;
         end
      end
   endtask

   task automatic run_vec(string tag);
      @(negedge clk);
      in_vld = v; in_inj = inj;
      for (int k = 0; k < 4; k++) begin
         in_ts[AW*k +: AW] = ts[k];
         in_want[4*k +: 4] = w[k];
      end
      model();
      @(negedge clk);
      checks++;
      if (gnt_o !== exp_g || defl_o !== exp_d) begin
         errors++;
         $display("FAIL %s: gnt=%h defl=%b expected gnt=%h defl=%b", tag, gnt_o, defl_o, exp_g, exp_d);
      end
   endtask

   task automatic set4(logic [3:0] vv, logic [3:0] ii, int t0, int t1, int t2, int t3,
                       logic [3:0] w0, logic [3:0] w1, logic [3:0] w2, logic [3:0] w3);
      v = vv; inj = ii;
      ts[0] = AW'(t0); ts[1] = AW'(t1); ts[2] = AW'(t2); ts[3] = AW'(t3);
      w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired (all R)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      in_vld = 4'hF; in_want = 16'hFFFF;
      @(negedge clk);
      checks++;
      if (gnt_o !== '0 || defl_o !== '0) begin
         errors++;
         $display("FAIL R1 reset: gnt=%h defl=%b expected 0000/0000", gnt_o, defl_o);
      end
      rst = 1'b0;

      // R5/R6/R7: all want port 2, distinct ages, oldest is input 3
      set4(4'hF, 4'h0, 40, 30, 20, 10, 4'h4, 4'h4, 4'h4, 4'h4);
      run_vec("R5 R7 all want one port");
      // R5: equal ages, lower index wins
      set4(4'hF, 4'h0, 5, 5, 5, 5, 4'h1, 4'h1, 4'h1, 4'h1);
      run_vec("R5 tie by index");
      // R5: old injected flit loses to young network flit
      set4(4'h3, 4'h1, 0, 200, 0, 0, 4'h8, 4'h8, 4'h0, 4'h0);
      run_vec("R5 injected lowest");
      // R3: invalid flits take no port
      set4(4'h5, 4'h0, 1, 0, 2, 0, 4'h2, 4'h1, 4'h2, 4'h1);
      run_vec("R3 invalid ignored");
      // R6: no conflict, all productive
      set4(4'hF, 4'h0, 9, 8, 7, 6, 4'h2, 4'h1, 4'h8, 4'h4);
      run_vec("R6 all productive");
      // R6: multi-bit masks take lowest free in overlap
      set4(4'hF, 4'h0, 1, 2, 3, 4, 4'hC, 4'hC, 4'hC, 4'h3);
      run_vec("R6 lowest in overlap");
      // R7: empty mask deflects
      set4(4'hF, 4'h0, 1, 2, 3, 4, 4'h0, 4'h1, 4'h0, 4'h2);
      run_vec("R7 empty mask");
      // R8-ish unsigned full width compare covered under R5
      set4(4'h3, 4'h0, 255, 128, 0, 0, 4'h1, 4'h1, 4'h0, 4'h0);
      run_vec("R5 unsigned timestamp");
      // R2: nothing valid
      set4(4'h0, 4'h0, 0, 0, 0, 0, 4'hF, 4'hF, 4'hF, 4'hF);
      run_vec("R2 R3 idle");

      // R1: reset in mid-traffic
      set4(4'hF, 4'h0, 1, 2, 3, 4, 4'h1, 4'h2, 4'h4, 4'h8);
      run_vec("R2 before reset");
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      checks++;
      if (gnt_o !== '0 || defl_o !== '0) begin
         errors++;
         $display("FAIL R1 mid reset: gnt=%h defl=%b expected 0000/0000", gnt_o, defl_o);
      end
      rst = 1'b0;

      // random R2 R4 R5 R6 R7
      for (int n = 0; n < 3000; n++) begin
         bit narrow = $urandom_range(0, 1) == 1;
         v = 4'($urandom_range(0, 15));
         inj = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         for (int k = 0; k < 4; k++) begin
            ts[k] = narrow ? AW'($urandom_range(0, 3)) : AW'($urandom_range(0, 255));
            w[k]  = 4'($urandom_range(0, 15));
         end
         run_vec("R4 R5 R6 R7 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule